// File: doc/BRIEF.md
# Indirect-Addressed Host Register Bridge

This block connects an asynchronous 16-bit host bus to a clocked core. The host has no clock of its own. It stages a 32-bit configuration word into a holding register, one 16-bit half at a time. It then names the internal register that should receive the word by writing an internal address to a third direct location. The bridge carries that request into the core clock domain. It presents the internal address and the 32-bit word on registered outputs, together with a write strobe that is high for exactly one core clock.

Every host write strobe, gated by chip enable, passes through a synchronizer and an edge detector. The bridge samples the direct address and the bus data one register later, on the detected edge. A busy flag covers the window between the capture of a transfer request and the end of its strobe cycle. While busy is high, holding-register writes and further transfer requests have no effect. The host can read back both halves of the holding register, the last internal address and the busy flag. The bridge drives the data bus only while a read is in progress.

Top module: `hostreg_bridge`

## Requirements
- R1: A host write to direct address 0 loads holding bits 15:0, and a write to direct address 1 loads bits 31:16. Each half reads back at the address it was written to.
- R2: A write to direct address 2 produces one transfer. On it, `reg_addr` equals the low TGT_W bits of the written bus value, `reg_data` equals the holding register {address-1 half, address-0 half}, and `reg_we` is high for exactly one clock.
- R3: With SYNC_STAGES = 2, `reg_we` is high in the clock cycle that begins on the fourth rising clock edge after the write strobe becomes active. The first edge that samples the active strobe counts as edge one.
- R4: Bit 0 of direct address 3 is the busy flag, and bits 15:1 read 0. Busy rises on the third edge after the strobe, is high during the strobe cycle, and is low once that cycle ends. A host that polls every clock therefore sees it high exactly twice.
- R5: While busy is high, writes to addresses 0 and 1 leave the holding register unchanged, and a further write to address 2 produces no second strobe.
- R6: Reading direct address 2 returns the internal address of the last transfer, zero-extended. Addresses 4 to 7 read as 0. Writes to addresses 3 to 7 change nothing and produce no strobe.
- R7: The bridge drives `bus_data` only while `bus_cs_n` and `bus_rd_n` are both low. Otherwise the host's value on the bus is seen unaltered.
- R8: A write strobe given while `bus_cs_n` is high has no effect.
- R9: A synchronous active-high `rst` clears the holding register, the busy flag, `reg_we`, `reg_addr` and `reg_data`. It also cancels a transfer that is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | inout | BUS_W | Bidirectional host data bus |
| bus_addr | input | 3 | Direct address |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_cs_n | input | 1 | Chip enable, active low |
| reg_addr | output | TGT_W | Internal target address |
| reg_data | output | 2*BUS_W | Word transferred to the target |
| reg_we | output | 1 | One-clock write strobe to the target |

## Verification
The bench builds the bridge with BUS_W = 16 and SYNC_STAGES = 2, and it narrows TGT_W to 12. The narrow target width brings truncation of the address-2 value within reach, on both `reg_addr` and the read-back. The two-stage synchronizer gives a fixed four-edge latency. This lets the bench place a second write so that its capture lands inside the busy window, which exercises the lockout of both holding-register writes and repeated transfer requests.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  localparam int DIR_AW = 3;

  localparam logic [DIR_AW-1:0] DA_LO   = 3'd0;
  localparam logic [DIR_AW-1:0] DA_HI   = 3'd1;
  localparam logic [DIR_AW-1:0] DA_XFER = 3'd2;
  localparam logic [DIR_AW-1:0] DA_STAT = 3'd3;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LO   = 2'd1,
    OP_HI   = 2'd2,
    OP_XFER = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_ARMED  = 2'd1,
    XS_STROBE = 2'd2
  } xstate_e;

  function automatic op_e decode_op(input logic [DIR_AW-1:0] a);
    case (a)
      DA_LO:   decode_op = OP_LO;
      DA_HI:   decode_op = OP_HI;
      DA_XFER: decode_op = OP_XFER;
      default: decode_op = OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/hostreg_sync.sv
module hostreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise_o = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/hostreg_cmd.sv
module hostreg_cmd
  import hostreg_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic [DIR_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_in,
  output op_e               cmd_op,
  output logic [BUS_W-1:0]  cmd_data
);
  logic [DIR_AW-1:0] addr_q;
  logic [BUS_W-1:0]  data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= bus_addr;
      data_q <= bus_in;
    end
  end

  always_comb begin
    cmd_op   = rise ? decode_op(addr_q) : OP_NONE;
    cmd_data = data_q;
  end
endmodule

// File: rtl/hostreg_hold.sv
module hostreg_hold
  import hostreg_pkg::*;
#(
  parameter int BUS_W = 16,
  localparam int HOLD_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               cmd_op,
  input  logic [BUS_W-1:0]  cmd_data,
  input  logic              lock,
  output logic [HOLD_W-1:0] hold
);
  logic [BUS_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (!lock) begin
      if (cmd_op == OP_LO) lo_q <= cmd_data;
      if (cmd_op == OP_HI) hi_q <= cmd_data;
    end
  end

  assign hold = {hi_q, lo_q};
endmodule

// File: rtl/hostreg_xfer.sv
module hostreg_xfer
  import hostreg_pkg::*;
#(
  parameter int TGT_W  = 16,
  parameter int HOLD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               cmd_op,
  input  logic [TGT_W-1:0]  cmd_tgt,
  input  logic [HOLD_W-1:0] hold,
  output logic              busy,
  output logic [TGT_W-1:0]  reg_addr,
  output logic [HOLD_W-1:0] reg_data,
  output logic              reg_we
);
  xstate_e          state_q;
  logic [TGT_W-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= XS_IDLE;
      tgt_q    <= '0;
      reg_addr <= '0;
      reg_data <= '0;
      reg_we   <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      case (state_q)
        XS_IDLE: begin
          if (cmd_op == OP_XFER) begin
            tgt_q   <= cmd_tgt;
            state_q <= XS_ARMED;
          end
        end
        XS_ARMED: begin
          reg_addr <= tgt_q;
          reg_data <= hold;
          reg_we   <= 1'b1;
          state_q  <= XS_STROBE;
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign busy = (state_q != XS_IDLE);
endmodule

// File: rtl/hostreg_rdmux.sv
module hostreg_rdmux
  import hostreg_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int TGT_W = 16,
  localparam int HOLD_W = 2 * BUS_W
) (
  input  logic [DIR_AW-1:0] rd_addr,
  input  logic [HOLD_W-1:0] hold,
  input  logic [TGT_W-1:0]  last_tgt,
  input  logic              busy,
  output logic [BUS_W-1:0]  rd_data
);
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      DA_LO:   rd_data = hold[BUS_W-1:0];
      DA_HI:   rd_data = hold[HOLD_W-1:BUS_W];
      DA_XFER: rd_data[TGT_W-1:0] = last_tgt;
      DA_STAT: rd_data[0] = busy;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/hostreg_bridge.sv
module hostreg_bridge
  import hostreg_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int TGT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int HOLD_W     = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  inout  wire [BUS_W-1:0]   bus_data,
  input  logic [DIR_AW-1:0] bus_addr,
  input  logic              bus_wr_n,
  input  logic              bus_rd_n,
  input  logic              bus_cs_n,
  output logic [TGT_W-1:0]  reg_addr,
  output logic [HOLD_W-1:0] reg_data,
  output logic              reg_we
);
  logic              wr_act, rise_w, busy_w, rd_oe;
  op_e               op_w;
  logic [BUS_W-1:0]  cmd_data_w, rd_data_w;
  logic [HOLD_W-1:0] hold_w;

  initial begin
    if (TGT_W > BUS_W) $error("TGT_W must not exceed BUS_W");
  end

  assign wr_act = ~bus_wr_n & ~bus_cs_n;
  assign rd_oe  = ~bus_rd_n & ~bus_cs_n;

  hostreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(wr_act), .rise_o(rise_w)
  );

  hostreg_cmd #(.BUS_W(BUS_W)) u_cmd (
    .clk(clk), .rst(rst), .rise(rise_w), .bus_addr(bus_addr),
    .bus_in(bus_data), .cmd_op(op_w), .cmd_data(cmd_data_w)
  );

  hostreg_hold #(.BUS_W(BUS_W)) u_hold (
    .clk(clk), .rst(rst), .cmd_op(op_w), .cmd_data(cmd_data_w),
    .lock(busy_w), .hold(hold_w)
  );

  hostreg_xfer #(.TGT_W(TGT_W), .HOLD_W(HOLD_W)) u_xfer (
    .clk(clk), .rst(rst), .cmd_op(op_w), .cmd_tgt(cmd_data_w[TGT_W-1:0]),
    .hold(hold_w), .busy(busy_w), .reg_addr(reg_addr),
    .reg_data(reg_data), .reg_we(reg_we)
  );

  hostreg_rdmux #(.BUS_W(BUS_W), .TGT_W(TGT_W)) u_rdmux (
    .rd_addr(bus_addr), .hold(hold_w), .last_tgt(reg_addr),
    .busy(busy_w), .rd_data(rd_data_w)
  );

  assign bus_data = rd_oe ? rd_data_w : {BUS_W{1'bz}};
endmodule

// File: rtl/hostreg_bridge_chk.sv
module hostreg_bridge_chk #(
  parameter int HOLD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic              busy,
  input logic [HOLD_W-1:0] hold
);
  // R2: the target strobe never lasts longer than one clock
  a_r2_we_one_cycle: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R4: busy covers the strobe cycle
  a_r4_busy_during_we: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> busy);

  // R4: busy is gone once the strobe cycle has ended
  a_r4_busy_drops: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !busy);

  // R3: the strobe follows one clock after busy rises
  a_r3_arm_then_we: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> reg_we);

  // R5: the holding register is frozen while busy
  a_r5_hold_locked: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(hold));
endmodule

bind hostreg_bridge hostreg_bridge_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .busy(busy_w), .hold(hold_w)
);

// File: tb/hostreg_bridge_bench.sv
module hostreg_bridge_bench;
  localparam int BW = 16;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    b_addr = '0;
  logic [BW-1:0] b_drv = '0;
  logic          b_oe = 1'b0;
  logic          wr_n = 1'b1, rd_n = 1'b1, cs_n = 1'b1;
  wire  [BW-1:0] bus;
  logic [TW-1:0] reg_addr;
  logic [2*BW-1:0] reg_data;
  logic          reg_we;

  int checks = 0, errors = 0;
  int cyc = 0, wr_cyc = 0, we_cyc = 0, we_cnt = 0, we_run = 0, we_maxrun = 0;
  logic [TW-1:0]   we_addr;
  logic [2*BW-1:0] we_data;
  logic [BW-1:0]   rv;

  assign bus = b_oe ? b_drv : {BW{1'bz}};

  hostreg_bridge #(.BUS_W(BW), .TGT_W(TW), .SYNC_STAGES(2)) u_hostreg_bridge (
    .clk(clk), .rst(rst), .bus_data(bus), .bus_addr(b_addr),
    .bus_wr_n(wr_n), .bus_rd_n(rd_n), .bus_cs_n(cs_n),
    .reg_addr(reg_addr), .reg_data(reg_data), .reg_we(reg_we)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (reg_we) begin
      we_cnt  <= we_cnt + 1;
      we_cyc  <= cyc;
      we_addr <= reg_addr;
      we_data <= reg_data;
      we_run  <= we_run + 1;
      if (we_run + 1 > we_maxrun) we_maxrun <= we_run + 1;
    end else begin
      we_run <= 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [BW-1:0] d, input logic cs);
    @(negedge clk);
    b_addr = a; b_drv = d; b_oe = 1'b1;
    cs_n = ~cs; wr_n = 1'b0;
    wr_cyc = cyc;
    #1 chk("R7 bus undisturbed while host drives", 64'(bus), 64'(d));
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic hread(input logic [2:0] a, output logic [BW-1:0] v);
    @(negedge clk);
    b_oe = 1'b0; b_addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1 v = bus;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {low half, high half, target value}
  localparam logic [47:0] VEC [6] = '{
    {16'h1234, 16'h5678, 16'h0014},
    {16'hFFFF, 16'h0000, 16'h0FFF},
    {16'h0000, 16'hFFFF, 16'h0000},
    {16'hA5A5, 16'h5A5A, 16'hFABC},
    {16'h0001, 16'h8000, 16'h1015},
    {16'hC9C9, 16'h4A4A, 16'h0800}
  };

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int base;
    int ones;
    logic [BW-1:0] lo_keep, hi_keep;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R9 reset state
    chk("R9 reg_we after reset", 64'(reg_we), 64'd0);
    chk("R9 reg_data after reset", 64'(reg_data), 64'd0);
    hread(3'd0, rv); chk("R9 low half after reset", 64'(rv), 64'd0);
    hread(3'd3, rv); chk("R9 busy after reset", 64'(rv), 64'd0);

    // Table walk: R1 R2 R3
    for (int i = 0; i < 6; i++) begin
      base = we_cnt;
      hwrite(3'd0, VEC[i][47:32], 1'b1); idle(2);
      hwrite(3'd1, VEC[i][31:16], 1'b1); idle(2);
      hwrite(3'd2, VEC[i][15:0], 1'b1);  idle(6);
      chk("R2 one strobe per transfer", 64'(we_cnt - base), 64'd1);
      chk("R2 target address", 64'(we_addr), 64'(VEC[i][TW-1:0]));
      chk("R2 transferred word", 64'(we_data), 64'({VEC[i][31:16], VEC[i][47:32]}));
      chk("R3 strobe on fourth edge", 64'(we_cyc - wr_cyc), 64'd4);
      chk("R2 strobe width", 64'(we_maxrun), 64'd1);
      hread(3'd0, rv); chk("R1 low half readback", 64'(rv), 64'(VEC[i][47:32]));
      hread(3'd1, rv); chk("R1 high half readback", 64'(rv), 64'(VEC[i][31:16]));
      hread(3'd2, rv); chk("R6 target readback", 64'(rv), 64'(VEC[i][TW-1:0]));
    end
    lo_keep = VEC[5][47:32];
    hi_keep = VEC[5][31:16];

    // R4 busy window, polled every clock
    hwrite(3'd2, 16'h0123, 1'b1);
    ones = 0;
    for (int k = 0; k < 8; k++) begin
      hread(3'd3, rv);
      if (rv[0]) ones++;
      chk("R4 status upper bits", 64'(rv[BW-1:1]), 64'd0);
    end
    chk("R4 busy samples", 64'(ones), 64'd2);

    // R5 holding write inside busy window ignored
    base = we_cnt;
    hwrite(3'd2, 16'h0456, 1'b1);
    hwrite(3'd0, 16'hDEAD, 1'b1);
    idle(6);
    hread(3'd0, rv); chk("R5 low half locked while busy", 64'(rv), 64'(lo_keep));
    chk("R5 single strobe", 64'(we_cnt - base), 64'd1);

    // R5 second transfer request inside busy window ignored
    base = we_cnt;
    hwrite(3'd2, 16'h0111, 1'b1);
    hwrite(3'd2, 16'h0222, 1'b1);
    idle(8);
    chk("R5 repeated request gives one strobe", 64'(we_cnt - base), 64'd1);
    chk("R5 first request kept", 64'(we_addr), 64'h111);

    // R8 chip enable high
    base = we_cnt;
    hwrite(3'd1, 16'hBEEF, 1'b0); idle(3);
    hwrite(3'd2, 16'h0333, 1'b0); idle(6);
    hread(3'd1, rv); chk("R8 write without chip enable", 64'(rv), 64'(hi_keep));
    chk("R8 no strobe without chip enable", 64'(we_cnt - base), 64'd0);

    // R6 other addresses
    hwrite(3'd3, 16'hFFFF, 1'b1); idle(3);
    hwrite(3'd5, 16'h7777, 1'b1); idle(6);
    chk("R6 no strobe for addresses 3 to 7", 64'(we_cnt - base), 64'd0);
    hread(3'd3, rv); chk("R6 status unaffected by write", 64'(rv), 64'd0);
    hread(3'd0, rv); chk("R6 low half unaffected", 64'(rv), 64'(lo_keep));
    for (int a = 4; a < 8; a++) begin
      hread(3'(a), rv); chk("R6 unused address reads zero", 64'(rv), 64'd0);
    end

    // R9 reset cancels a transfer in progress
    base = we_cnt;
    hwrite(3'd2, 16'h0444, 1'b1);
    @(negedge clk); @(negedge clk);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    idle(6);
    chk("R9 reset cancels transfer", 64'(we_cnt - base), 64'd0);
    chk("R9 reg_addr cleared", 64'(reg_addr), 64'd0);
    hread(3'd1, rv); chk("R9 high half cleared", 64'(rv), 64'd0);
    hread(3'd3, rv); chk("R9 busy cleared", 64'(rv), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule